// File: doc/BRIEF.md
# Event Counter with Switchable Prescaler

This block is an 8-bit event counter for a small controller core. Each count step comes from one of two sources: the core's instruction-cycle enable, or an edge of one chosen polarity on an external input pin. The pin is synchronized into the system clock domain before its edges are detected. Software can load the counter through a write port, and the counter value is always visible. When the counter wraps from all ones to zero it raises a pulse one clock long. Software uses that pulse as the overflow interrupt request.

A single 8-bit prescaler serves either the counter or a watchdog, never both at once. When the counter owns it, counter events are divided by 2^(rate+1), from 1:2 up to 1:256. When the watchdog owns it, raw watchdog events are divided by 2^rate, from 1:1 up to 1:128, and the counter then takes every source event undivided. The prescaler count is cleared only by a write to the counter, so software writes the counter whenever it needs a known division phase.

Top module: `rtc_timer`

## Requirements
- R1: After reset the counter value is 0x00, the overflow pulse and the watchdog tick are low, and the control word is all ones. With the control word all ones the source is the external pin on falling edges, the prescaler belongs to the watchdog, and the rate is 7.
- R2: When control bit 5 is 0, the count source is the instruction-cycle enable. Each clock with `cyc_en` high is one source event.
- R3: When control bit 5 is 1, the count source is the external pin after a two-flop synchronizer. Control bit 4 at 0 counts low-to-high transitions and at 1 counts high-to-low transitions. The opposite transition and `cyc_en` are ignored.
- R4: When control bit 3 is 0, the prescaler belongs to the counter. The counter advances once per 2^(rate+1) source events, where rate is control bits [2:0]. No step is ever larger than one.
- R5: When control bit 3 is 1, the counter advances on every source event. `wdt_tick` pulses once per 2^rate pulses of `wdt_evt`.
- R6: When control bit 3 is 0, `wdt_tick` repeats each `wdt_evt` pulse one clock later, and watchdog events do not move the counter.
- R7: A counter write loads `cnt_wdata` at the next edge and clears the prescaler count. A write in the same clock as a count event wins. Control writes do not clear the prescaler.
- R8: `ovf_pulse` is high for exactly one clock when an increment takes the counter from 0xFF to 0x00, and it is never raised by a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_en | input | 1 | Instruction-cycle enable, one source event per high clock |
| ext_pin | input | 1 | Asynchronous external count input |
| wdt_evt | input | 1 | Raw watchdog time-base event |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 6 | Control word: [5] external source, [4] falling edge, [3] prescaler to watchdog, [2:0] rate |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 8 | Counter load value |
| cnt_q | output | 8 | Counter value |
| ovf_pulse | output | 1 | One-clock wrap pulse |
| wdt_tick | output | 1 | Watchdog tick, prescaled when the watchdog owns the prescaler |

## Verification
Some checks hold on every clock, whatever the stimulus:
- The counter never moves by more than one step unless it is written.
- A write always lands, and a write never produces an overflow pulse.
- An overflow pulse only appears with the counter at zero and never on two clocks in a row.
- When the watchdog owns the prescaler, the counter steps once per source event.
- When the counter owns the prescaler, the watchdog tick mirrors its raw event.

The bench scenarios cover what those clock-by-clock checks cannot see. These are the division ratios at both ends of the rate field, edge polarity through the synchronizer, and the prescaler phase that survives a control write but is lost on a counter write. They also include the reset value of the control word, which is only visible through the 1:128 watchdog division that holds after reset.

// File: rtl/rtc_timer_pkg.sv
package rtc_timer_pkg;

    localparam int CNT_W   = 8;
    localparam int PSC_W   = 8;
    localparam int RATE_W  = 3;
    localparam int CTRL_W  = RATE_W + 3;
    localparam int SYNC_N  = 2;

    typedef enum logic {
        PSC_TO_CNT = 1'b0,
        PSC_TO_WDT = 1'b1
    } psc_owner_e;

    typedef struct packed {
        logic              src_ext;
        logic              edge_fall;
        psc_owner_e        owner;
        logic [RATE_W-1:0] rate;
    } tmr_ctrl_t;

    localparam tmr_ctrl_t CTRL_RST = tmr_ctrl_t'({CTRL_W{1'b1}});

    // Low bits of the prescaler that must all be one for the next event
    // to complete a division period.
    function automatic logic [PSC_W-1:0] tap_mask(input logic [RATE_W-1:0] rate,
                                                  input psc_owner_e owner);
        logic [PSC_W-1:0] m;
        int n;
        n = int'(rate) + ((owner == PSC_TO_CNT) ? 1 : 0);
        for (int i = 0; i < PSC_W; i++) begin
            m[i] = (i < n);
        end
        return m;
    endfunction

endpackage

// File: rtl/rtc_edge_sync.sv
module rtc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic edge_fall,
    output logic evt
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              prev;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= pin;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= chain[LAST];
    end

    logic rise, fall;
    always_comb begin
        rise = chain[LAST] & ~prev;
        fall = ~chain[LAST] & prev;
        evt  = edge_fall ? fall : rise;
    end

endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             evt,
    input  logic [WIDTH-1:0] mask,
    output logic             tick
);
    logic [WIDTH-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst || clr) div_q <= '0;
        else if (evt)   div_q <= div_q + 1'b1;
    end

    always_comb begin
        tick = evt && ((div_q & mask) == mask);
    end

endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [WIDTH-1:0] wdata,
    input  logic             inc,
    output logic [WIDTH-1:0] cnt_q,
    output logic             ovf_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= 1'b0;
            if (we) begin
                cnt_q <= wdata;
            end else if (inc) begin
                cnt_q <= cnt_q + 1'b1;
                ovf_q <= (cnt_q == {WIDTH{1'b1}});
            end
        end
    end

endmodule

// File: rtl/rtc_timer.sv
module rtc_timer
    import rtc_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_en,
    input  logic              ext_pin,
    input  logic              wdt_evt,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              cnt_we,
    input  logic [CNT_W-1:0]  cnt_wdata,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              ovf_pulse,
    output logic              wdt_tick
);
    tmr_ctrl_t        ctrl_q;
    logic             pin_evt;
    logic             src_evt;
    logic             psc_evt;
    logic             psc_tick;
    logic             cnt_inc;
    logic             psc_to_wdt;
    logic [PSC_W-1:0] mask;

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= CTRL_RST;
        else if (ctrl_we) ctrl_q <= tmr_ctrl_t'(ctrl_wdata);
    end

    rtc_edge_sync #(.STAGES(SYNC_N)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .pin       (ext_pin),
        .edge_fall (ctrl_q.edge_fall),
        .evt       (pin_evt)
    );

    always_comb begin
        psc_to_wdt = (ctrl_q.owner == PSC_TO_WDT);
        src_evt    = ctrl_q.src_ext ? pin_evt : cyc_en;
        psc_evt    = psc_to_wdt ? wdt_evt : src_evt;
        mask       = tap_mask(ctrl_q.rate, ctrl_q.owner);
        cnt_inc    = psc_to_wdt ? src_evt : psc_tick;
    end

    rtc_prescaler #(.WIDTH(PSC_W)) u_psc (
        .clk  (clk),
        .rst  (rst),
        .clr  (cnt_we),
        .evt  (psc_evt),
        .mask (mask),
        .tick (psc_tick)
    );

    rtc_counter #(.WIDTH(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .we    (cnt_we),
        .wdata (cnt_wdata),
        .inc   (cnt_inc),
        .cnt_q (cnt_q),
        .ovf_q (ovf_pulse)
    );

    always_ff @(posedge clk) begin
        if (rst) wdt_tick <= 1'b0;
        else     wdt_tick <= psc_to_wdt ? psc_tick : wdt_evt;
    end

endmodule

// File: rtl/rtc_timer_chk.sv
module rtc_timer_chk
    import rtc_timer_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cnt_we,
    input logic [CNT_W-1:0] cnt_wdata,
    input logic [CNT_W-1:0] cnt_q,
    input logic             ovf_pulse,
    input logic             wdt_evt,
    input logic             wdt_tick,
    input logic             psc_to_wdt,
    input logic             src_evt
);
    // R7
    write_load_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_we |=> cnt_q == $past(cnt_wdata));

    // R8
    no_ovf_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_we |=> !ovf_pulse);

    // R8
    ovf_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_pulse |-> cnt_q == '0);

    // R8
    ovf_single_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_pulse |=> !ovf_pulse);

    // R4
    unit_step_chk: assert property (@(posedge clk) disable iff (rst)
        !cnt_we |=> (cnt_q == $past(cnt_q)) || (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

    // R5
    undivided_chk: assert property (@(posedge clk) disable iff (rst)
        (psc_to_wdt && src_evt && !cnt_we) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

    // R6
    wdt_pass_chk: assert property (@(posedge clk) disable iff (rst)
        !psc_to_wdt |=> wdt_tick == $past(wdt_evt));

endmodule

bind rtc_timer rtc_timer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cnt_we     (cnt_we),
    .cnt_wdata  (cnt_wdata),
    .cnt_q      (cnt_q),
    .ovf_pulse  (ovf_pulse),
    .wdt_evt    (wdt_evt),
    .wdt_tick   (wdt_tick),
    .psc_to_wdt (psc_to_wdt),
    .src_evt    (src_evt)
);

// File: tb/rtc_timer_test.sv
`timescale 1ns/1ps
module rtc_timer_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cyc_en = 1'b0;
    logic       ext_pin = 1'b0;
    logic       wdt_evt = 1'b0;
    logic       ctrl_we = 1'b0;
    logic [5:0] ctrl_wdata = '0;
    logic       cnt_we = 1'b0;
    logic [7:0] cnt_wdata = '0;
    logic [7:0] cnt_q;
    logic       ovf_pulse;
    logic       wdt_tick;

    always #2.5 clk = ~clk;

    rtc_timer uut (
        .clk        (clk),
        .rst        (rst),
        .cyc_en     (cyc_en),
        .ext_pin    (ext_pin),
        .wdt_evt    (wdt_evt),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (ctrl_wdata),
        .cnt_we     (cnt_we),
        .cnt_wdata  (cnt_wdata),
        .cnt_q      (cnt_q),
        .ovf_pulse  (ovf_pulse),
        .wdt_tick   (wdt_tick)
    );

    typedef struct {
        logic [7:0] cnt;
        int         ovf;
        int         wdt;
        string      req;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad = 0;
    int   ovf_n = 0;
    int   wdt_n = 0;
    bit   finished = 0;

    always @(posedge clk) begin
        if (!rst) begin
            if (ovf_pulse) ovf_n++;
            if (wdt_tick)  wdt_n++;
        end
    end

    // monitor: pops expected items and compares them with the outputs
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t it;
            it = exp_q.pop_front();
            total++;
            if (cnt_q !== it.cnt) begin
                bad++;
                $display("FAIL %s counter: actual=%h expected=%h", it.req, cnt_q, it.cnt);
            end
            total++;
            if (ovf_n != it.ovf) begin
                bad++;
                $display("FAIL %s overflow pulses: actual=%0d expected=%0d", it.req, ovf_n, it.ovf);
            end
            total++;
            if (wdt_n != it.wdt) begin
                bad++;
                $display("FAIL %s watchdog ticks: actual=%0d expected=%0d", it.req, wdt_n, it.wdt);
            end
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic expect_state(input logic [7:0] c, input int o, input int w, input string r);
        exp_t it;
        step(3);
        it.cnt = c; it.ovf = o; it.wdt = w; it.req = r;
        exp_q.push_back(it);
        wait (exp_q.size() == 0);
    endtask

    task automatic write_ctrl(input logic [5:0] v);
        @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_we = 1'b0;
    endtask

    task automatic write_cnt(input logic [7:0] v);
        @(negedge clk); cnt_we = 1'b1; cnt_wdata = v;
        @(negedge clk); cnt_we = 1'b0;
    endtask

    task automatic cyc_pulses(input int n);
        for (int i = 0; i < n; i++) begin @(negedge clk); cyc_en = 1'b1; end
        @(negedge clk); cyc_en = 1'b0;
    endtask

    task automatic wdt_pulses(input int n);
        for (int i = 0; i < n; i++) begin @(negedge clk); wdt_evt = 1'b1; end
        @(negedge clk); wdt_evt = 1'b0;
    endtask

    task automatic set_pin(input logic v);
        @(negedge clk); ext_pin = v;
        step(5);
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        // R1 reset state
        expect_state(8'h00, 0, 0, "R1");
        // R1 reset control: watchdog owns prescaler at 1:128
        wdt_pulses(127);
        expect_state(8'h00, 0, 0, "R1");
        wdt_pulses(1);
        expect_state(8'h00, 0, 1, "R1");
        // R1 reset source is the pin, cycle enable ignored
        cyc_pulses(10);
        expect_state(8'h00, 0, 1, "R1");
        // R3 falling edges counted, rising ignored
        set_pin(1'b1);
        expect_state(8'h00, 0, 1, "R3");
        set_pin(1'b0);
        expect_state(8'h01, 0, 1, "R3");
        // R3 rising edges selected
        write_ctrl(6'h28);
        set_pin(1'b1);
        expect_state(8'h02, 0, 1, "R3");
        set_pin(1'b0);
        expect_state(8'h02, 0, 1, "R3");
        // R5 watchdog 1:1
        wdt_pulses(3);
        expect_state(8'h02, 0, 4, "R5");
        // R2 internal source, undivided
        write_ctrl(6'h08);
        cyc_pulses(5);
        expect_state(8'h07, 0, 4, "R2");
        // R7 load, R4 1:2
        write_ctrl(6'h00);
        write_cnt(8'h10);
        expect_state(8'h10, 0, 4, "R7");
        cyc_pulses(4);
        expect_state(8'h12, 0, 4, "R4");
        cyc_pulses(1);
        expect_state(8'h12, 0, 4, "R4");
        cyc_pulses(1);
        expect_state(8'h13, 0, 4, "R4");
        // R4 1:8
        write_ctrl(6'h02);
        write_cnt(8'h30);
        cyc_pulses(7);
        expect_state(8'h30, 0, 4, "R4");
        cyc_pulses(1);
        expect_state(8'h31, 0, 4, "R4");
        cyc_pulses(16);
        expect_state(8'h33, 0, 4, "R4");
        // R7 write clears prescaler phase
        cyc_pulses(5);
        write_cnt(8'h40);
        cyc_pulses(7);
        expect_state(8'h40, 0, 4, "R7");
        cyc_pulses(1);
        expect_state(8'h41, 0, 4, "R7");
        // R6 watchdog passes through, counter untouched
        wdt_pulses(5);
        expect_state(8'h41, 0, 9, "R6");
        // R8 wrap
        write_ctrl(6'h08);
        write_cnt(8'hFE);
        cyc_pulses(1);
        expect_state(8'hFF, 0, 9, "R8");
        cyc_pulses(1);
        expect_state(8'h00, 1, 9, "R8");
        // R8 writes never pulse
        write_cnt(8'hFF);
        write_cnt(8'h05);
        expect_state(8'h05, 1, 9, "R8");
        // R7 write wins over a simultaneous event
        @(negedge clk); cnt_we = 1'b1; cnt_wdata = 8'h80; cyc_en = 1'b1;
        @(negedge clk); cnt_we = 1'b0; cyc_en = 1'b0;
        expect_state(8'h80, 1, 9, "R7");
        // R4 1:256
        write_ctrl(6'h07);
        write_cnt(8'h00);
        cyc_pulses(255);
        expect_state(8'h00, 1, 9, "R4");
        cyc_pulses(1);
        expect_state(8'h01, 1, 9, "R4");
        // R5 watchdog 1:128 after a clearing write
        write_ctrl(6'h0F);
        write_cnt(8'h00);
        wdt_pulses(127);
        expect_state(8'h00, 1, 9, "R5");
        wdt_pulses(1);
        expect_state(8'h00, 1, 10, "R5");
        // R3 rising edges through the 1:2 prescaler
        write_ctrl(6'h20);
        write_cnt(8'h00);
        set_pin(1'b1);
        expect_state(8'h00, 1, 10, "R3");
        set_pin(1'b0);
        set_pin(1'b1);
        expect_state(8'h01, 1, 10, "R3");
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule